// File: doc/BRIEF.md
# Keypad Lock Sequencer

This block decides whether key events may reach the event queue. While it is locked, it looks at each incoming key event and compares the 7-bit code and the press/release bit with a programmed unlock event. When only one unlock event is configured, a single match opens the keypad. When two are configured, the first match moves the sequencer into a pending stage. The second programmed event then completes the unlock.

An optional expiry timer limits how long the pending stage may last. The timer counts ticks from a 1 Hz timebase. If the set number of ticks passes before the second event arrives, the sequencer falls back to fully locked. Software locks the keypad by pulsing a lock request. This forces the locked state at once and discards any partial progress.

While the keypad is open, every event is forwarded to the queue one cycle later. Events that arrive while it is locked or pending are swallowed, and so are the unlock events themselves.

Top module: `kp_lock_seq`

## Requirements
- R1: After reset the sequencer is open: `locked_o`=0, `pend_o`=0, `fwd_vld_o`=0.
- R2: A `lock_req_i` pulse makes `locked_o`=1 and `pend_o`=0 after the next clock edge from any state, clears any running timer, and takes priority over a matching unlock event in the same cycle.
- R3: With `need2_i`=0, a locked sequencer that sees an event equal to the first unlock code and state bit shows `locked_o`=0 after that edge.
- R4: While locked, an event that differs from the first unlock event in any code bit or in the state bit (1 = press, 0 = release) leaves `locked_o`=1.
- R5: With `need2_i`=1, a first-event match gives `locked_o`=1 and `pend_o`=1. A following match of the second unlock event then gives `locked_o`=0 and `pend_o`=0.
- R6: While pending, events that do not match the second unlock event (a repeat of the first one included) leave the sequencer pending.
- R7: `tmr_sel_i` (3 bits) is sampled at the first match. A value N>0 returns the sequencer to locked with `pend_o`=0 on the Nth `tick_i` after that match. A value of 0 never expires.
- R8: If the second unlock event arrives in the same cycle as the expiring tick, the unlock wins.
- R9: While open, each event appears on `fwd_vld_o`/`fwd_code_o`/`fwd_st_o` one cycle later. Events seen while locked or pending, including unlock events, are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req_i | input | 1 | Software lock pulse |
| need2_i | input | 1 | Second unlock event required |
| tmr_sel_i | input | 3 | Pending timeout in ticks, 0 = none |
| unl1_code_i | input | 7 | First unlock event code |
| unl1_st_i | input | 1 | First unlock event state bit |
| unl2_code_i | input | 7 | Second unlock event code |
| unl2_st_i | input | 1 | Second unlock event state bit |
| tick_i | input | 1 | 1 Hz timebase strobe |
| evt_vld_i | input | 1 | Key event strobe |
| evt_code_i | input | 7 | Key event code |
| evt_st_i | input | 1 | Key event state bit (1 = press) |
| locked_o | output | 1 | Keypad locked; gates queue updates |
| pend_o | output | 1 | First unlock event seen, waiting for second |
| fwd_vld_o | output | 1 | Event forwarded to queue |
| fwd_code_o | output | 7 | Forwarded event code |
| fwd_st_o | output | 1 | Forwarded event state bit |

## Verification
Two pairs of functions can land in one cycle. The first pair is the software lock and an event. The second pair is the final timer tick and the second unlock event. The bench drives a lock request together with a key that would unlock. The lock must win, and the key must still be forwarded because the keypad was open during that cycle. It also drives the second unlock event on the very tick that would expire the timer, and expects the sequencer to open rather than relock.

// File: rtl/kp_lock_pkg.sv
package kp_lock_pkg;
  // bit 0 = locked, bit 1 = pending second event
  typedef enum logic [1:0] {
    ST_OPEN = 2'b00,
    ST_SHUT = 2'b01,
    ST_HALF = 2'b11
  } lk_state_t;
endpackage

// File: rtl/kp_evt_match.sv
module kp_evt_match #(
  parameter int CODE_W = 7
) (
  input  logic              vld,
  input  logic [CODE_W-1:0] code,
  input  logic              st,
  input  logic [CODE_W-1:0] ref_code,
  input  logic              ref_st,
  output logic              hit
);
  always_comb hit = vld && (code == ref_code) && (st == ref_st);
endmodule

// File: rtl/kp_unlock_tmr.sv
module kp_unlock_tmr #(
  parameter int TMR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)            cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  always_comb expire = tick && (cnt == TMR_W'(1)) && !clr && !load;

  // R7
  tmr_nonincr_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr && cnt != 0) |=> (cnt <= $past(cnt)));

  // R7
  tmr_idle_after_exp_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == 0));
endmodule

// File: rtl/kp_lock_fsm.sv
module kp_lock_fsm
  import kp_lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lock_req,
  input  logic need2,
  input  logic hit1,
  input  logic hit2,
  input  logic expire,
  output logic tmr_load,
  output logic tmr_clr,
  output logic locked,
  output logic pend
);
  lk_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OPEN: if (lock_req) nxt = ST_SHUT;
      ST_SHUT: begin
        if (lock_req)  nxt = ST_SHUT;
        else if (hit1) nxt = need2 ? ST_HALF : ST_OPEN;
      end
      ST_HALF: begin
        if (lock_req)    nxt = ST_SHUT;
        else if (hit2)   nxt = ST_OPEN;
        else if (expire) nxt = ST_SHUT;
      end
      default: nxt = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OPEN;
    else     state <= nxt;
  end

  always_comb begin
    tmr_load = (state == ST_SHUT) && hit1 && need2 && !lock_req;
    tmr_clr  = lock_req || ((state == ST_HALF) && hit2);
    locked   = state[0];
    pend     = state[1];
  end

  // R2
  lock_force_chk: assert property (@(posedge clk) disable iff (rst)
    lock_req |=> (locked && !pend));

  // R5
  pend_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(locked && hit1));

  // R3
  unlock_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(hit1 || hit2));

  // R7
  exp_relock_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && expire && !hit2 && !lock_req) |=> (locked && !pend));

  // R5
  pend_implies_lock_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> locked);
endmodule

// File: rtl/kp_lock_seq.sv
module kp_lock_seq #(
  parameter int CODE_W = 7,
  parameter int TMR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_req_i,
  input  logic              need2_i,
  input  logic [TMR_W-1:0]  tmr_sel_i,
  input  logic [CODE_W-1:0] unl1_code_i,
  input  logic              unl1_st_i,
  input  logic [CODE_W-1:0] unl2_code_i,
  input  logic              unl2_st_i,
  input  logic              tick_i,
  input  logic              evt_vld_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              evt_st_i,
  output logic              locked_o,
  output logic              pend_o,
  output logic              fwd_vld_o,
  output logic [CODE_W-1:0] fwd_code_o,
  output logic              fwd_st_o
);
  localparam int N_UNL = 2;

  logic [CODE_W-1:0] ref_code [N_UNL];
  logic              ref_st   [N_UNL];
  logic [N_UNL-1:0]  hit;
  logic              tmr_load, tmr_clr, expire;

  always_comb begin
    ref_code[0] = unl1_code_i;
    ref_st[0]   = unl1_st_i;
    ref_code[1] = unl2_code_i;
    ref_st[1]   = unl2_st_i;
  end

  for (genvar gi = 0; gi < N_UNL; gi++) begin : g_match
    kp_evt_match #(.CODE_W(CODE_W)) u_match (
      .vld      (evt_vld_i),
      .code     (evt_code_i),
      .st       (evt_st_i),
      .ref_code (ref_code[gi]),
      .ref_st   (ref_st[gi]),
      .hit      (hit[gi])
    );
  end

  kp_unlock_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr      (tmr_clr),
    .load     (tmr_load),
    .load_val (tmr_sel_i),
    .tick     (tick_i),
    .expire   (expire)
  );

  kp_lock_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .lock_req (lock_req_i),
    .need2    (need2_i),
    .hit1     (hit[0]),
    .hit2     (hit[1]),
    .expire   (expire),
    .tmr_load (tmr_load),
    .tmr_clr  (tmr_clr),
    .locked   (locked_o),
    .pend     (pend_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_vld_o  <= 1'b0;
      fwd_code_o <= '0;
      fwd_st_o   <= 1'b0;
    end else begin
      fwd_vld_o <= evt_vld_i && !locked_o;
      if (evt_vld_i && !locked_o) begin
        fwd_code_o <= evt_code_i;
        fwd_st_o   <= evt_st_i;
      end
    end
  end

  // R9
  fwd_open_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_vld_o |-> $past(!locked_o && evt_vld_i));
endmodule

// File: tb/sim_kp_lock_seq.sv
module sim_kp_lock_seq;
  logic clk = 1'b0;
  logic rst;
  logic lock_req, need2, tick, evt_vld, evt_st;
  logic [2:0] tmr_sel;
  logic [6:0] evt_code;
  logic locked, pend, fwd_vld, fwd_st;
  logic [6:0] fwd_code;
  int n_chk = 0, n_bad = 0;

  localparam logic [6:0] U1C = 7'h15;
  localparam logic       U1S = 1'b1;
  localparam logic [6:0] U2C = 7'h2A;
  localparam logic       U2S = 1'b0;

  always #2 clk = ~clk;

  kp_lock_seq u0 (
    .clk(clk), .rst(rst), .lock_req_i(lock_req), .need2_i(need2),
    .tmr_sel_i(tmr_sel), .unl1_code_i(U1C), .unl1_st_i(U1S),
    .unl2_code_i(U2C), .unl2_st_i(U2S), .tick_i(tick),
    .evt_vld_i(evt_vld), .evt_code_i(evt_code), .evt_st_i(evt_st),
    .locked_o(locked), .pend_o(pend), .fwd_vld_o(fwd_vld),
    .fwd_code_o(fwd_code), .fwd_st_o(fwd_st)
  );

  // {lock, vld, code[6:0], st, tick, need2, tmr[2:0], exp_locked, exp_pend, exp_fwd}
  localparam int NV = 26;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b0,7'h00,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0}, // idle open R1
    {1'b0,1'b1,7'h05,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1}, // forward R9
    {1'b1,1'b0,7'h00,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0}, // lock R2
    {1'b0,1'b1,7'h15,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0}, // wrong state R4
    {1'b0,1'b1,7'h14,1'b1,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0}, // wrong code R4
    {1'b0,1'b1,7'h15,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0}, // single unlock R3
    {1'b0,1'b1,7'h33,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1}, // forward R9
    {1'b1,1'b1,7'h15,1'b1,1'b0,1'b0,3'd0,1'b1,1'b0,1'b1}, // lock+event R2
    {1'b0,1'b1,7'h15,1'b1,1'b0,1'b1,3'd0,1'b1,1'b1,1'b0}, // first match R5
    {1'b0,1'b1,7'h07,1'b1,1'b0,1'b1,3'd0,1'b1,1'b1,1'b0}, // other key R6
    {1'b0,1'b0,7'h00,1'b0,1'b1,1'b1,3'd0,1'b1,1'b1,1'b0}, // tick, tmr 0 R7
    {1'b0,1'b1,7'h15,1'b1,1'b0,1'b1,3'd0,1'b1,1'b1,1'b0}, // repeat first R6
    {1'b0,1'b1,7'h2A,1'b0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0}, // second match R5
    {1'b1,1'b0,7'h00,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,1'b0}, // lock R2
    {1'b0,1'b1,7'h15,1'b1,1'b0,1'b1,3'd2,1'b1,1'b1,1'b0}, // first, tmr 2 R7
    {1'b0,1'b0,7'h00,1'b0,1'b1,1'b1,3'd0,1'b1,1'b1,1'b0}, // tick 1 R7
    {1'b0,1'b0,7'h00,1'b0,1'b1,1'b1,3'd0,1'b1,1'b0,1'b0}, // tick 2 expire R7
    {1'b0,1'b1,7'h2A,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,1'b0}, // second alone R4
    {1'b0,1'b1,7'h15,1'b1,1'b0,1'b1,3'd2,1'b1,1'b1,1'b0}, // first, tmr 2 R8
    {1'b0,1'b0,7'h00,1'b0,1'b1,1'b1,3'd0,1'b1,1'b1,1'b0}, // tick 1 R8
    {1'b0,1'b1,7'h2A,1'b0,1'b1,1'b1,3'd0,1'b0,1'b0,1'b0}, // tick 2 + second R8
    {1'b0,1'b1,7'h2A,1'b0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b1}, // forward R9
    {1'b1,1'b0,7'h00,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,1'b0}, // lock R2
    {1'b0,1'b1,7'h15,1'b1,1'b0,1'b1,3'd1,1'b1,1'b1,1'b0}, // first, tmr 1 R5
    {1'b0,1'b1,7'h2A,1'b1,1'b0,1'b1,3'd0,1'b1,1'b1,1'b0}, // second wrong st R6
    {1'b0,1'b1,7'h2A,1'b0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0}  // second match R5
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic v, input logic [6:0] c,
                       input logic s, input logic t, input logic n2,
                       input logic [2:0] tm);
    lock_req = l; evt_vld = v; evt_code = c; evt_st = s;
    tick = t; need2 = n2; tmr_sel = tm;
    @(posedge clk); #1;
  endtask

  initial begin
    #180000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    lock_req = 0; evt_vld = 0; evt_code = 0; evt_st = 0;
    tick = 0; need2 = 0; tmr_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 locked", locked, 0);
    chk("R1 pend", pend, 0);
    chk("R1 fwd", fwd_vld, 0);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      drive(v[17], v[16], v[15:9], v[8], v[7], v[6], v[5:3]);
      chk($sformatf("R2-7 locked vec%0d", i), locked, v[2]);
      chk($sformatf("R5 pend vec%0d", i), pend, v[1]);
      chk($sformatf("R9 fwd vec%0d", i), fwd_vld, v[0]);
      if (v[0]) begin
        chk($sformatf("R9 code vec%0d", i), fwd_code, v[15:9]);
        chk($sformatf("R9 st vec%0d", i), fwd_st, v[8]);
      end
    end

    // R2: lock during pending clears the timer; a later tmr 0 entry never expires
    drive(1, 0, 0, 0, 0, 1, 0);
    drive(0, 1, U1C, U1S, 0, 1, 1);
    chk("R7 pend tmr1", pend, 1);
    drive(1, 0, 0, 0, 0, 1, 0);
    chk("R2 lock from pend", pend, 0);
    chk("R2 lock from pend locked", locked, 1);
    drive(0, 1, U1C, U1S, 0, 1, 0);
    for (int k = 0; k < 3; k++) drive(0, 0, 0, 0, 1, 1, 0);
    chk("R7 tmr0 no expiry", pend, 1);
    drive(0, 1, U2C, U2S, 0, 1, 0);
    chk("R5 open after late second", locked, 0);

    // R1: reset in mid-operation returns to open
    drive(1, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    chk("R1 reset reopens", locked, 0);
    chk("R1 reset pend", pend, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule